// File: doc/BRIEF.md
# VCO band calibration controller

This controller tunes a multi-core oscillator coarsely before the frequency loop is allowed to lock. On a trigger, it tries each of the oscillator cores at the middle band. It keeps the core whose count lands nearest the target. It then runs a most-significant-bit-first binary search over the band code of that core.

Each trial drives a core and a band code onto the oscillator. It then sums the divided-oscillator edge increments (`osc_inc`, one value per reference cycle) over a fixed window of reference cycles and compares the sum with a target count. A raised band code adds tuning capacitance, which lowers the frequency.

The target comes from one of two programming banks, picked by `mode` when the run is accepted. The final band, the chosen core and a failure flag appear on readback outputs. The relock request bit is also readable there.

The state machine has four states:
- `ST_IDLE`: waiting for a trigger. It moves to `ST_CORE` when a trigger is accepted.
- `ST_CORE`: core survey. It moves to the next core after each window. After the last core it moves to `ST_BAND`.
- `ST_BAND`: band search, one window per bit. After the least significant bit it moves to `ST_FINISH`.
- `ST_FINISH`: lasts one cycle and returns to `ST_IDLE`.

Top module: `vco_band_cal`

## Requirements
- R1: A run is accepted in `ST_IDLE` on a rising edge of `enable`. A level that stays high does not start another run.
- R2: A one-cycle `relock_wr` sets a request bit that is visible on `rb_relock`. The bit starts a run and clears itself when that run is accepted. A request written during a run is held and starts a new run after the current one ends.
- R3: A rising edge of `enable` while `busy` is high is ignored and never starts a run.
- R4: Core survey. Each core, in the order 0, 1, 2, is measured at band 64. The core with the smallest absolute difference between its count and the target is chosen. On a tie, the lower core index wins. The chosen core is reported on `rb_core`.
- R5: Band search. The bits are tried from bit 6 down to bit 0. A trial bit is kept when the window count (the sum of `osc_inc` over `WIN_CYCLES` cycles) is strictly greater than the target. For an oscillator whose count falls as the band code rises, the result is the largest band whose count exceeds the target, or 0 if there is none.
- R6: The target is `bank1_target` when `mode` is 1 and `bank0_target` when `mode` is 0. It is sampled when the run is accepted.
- R7: `rb_fail` is 1 when the final band is 0 or 127. It is 0 for final bands 1 to 126.
- R8: `busy` is high from the cycle after acceptance through the cycle of `done`. `done` is a one-cycle pulse. `rb_band`, `rb_core` and `rb_fail` already hold the new result in the `done` cycle.
- R9: `lock_en` rises in the cycle after `done`. It stays low for the whole of every run.
- R10: After reset, `busy`, `done`, `lock_en`, `rb_band`, `rb_core`, `rb_fail` and `rb_relock` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Device enable; a rising edge triggers a run |
| relock_wr | input | 1 | Pulse that sets the relock request bit |
| mode | input | 1 | Selects the programming bank that supplies the target |
| bank0_target | input | CNT_W | Target count of bank 0 |
| bank1_target | input | CNT_W | Target count of bank 1 |
| osc_inc | input | INC_W | Divided oscillator edges seen in the current reference cycle |
| core_sel | output | CORE_W | Oscillator core under test or in use |
| band_sel | output | BAND_W | Band code driven to the oscillator |
| busy | output | 1 | Calibration run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| lock_en | output | 1 | Releases the PLL lock stage |
| rb_band | output | BAND_W | Readback: final band code |
| rb_fail | output | 1 | Readback: calibration failed |
| rb_core | output | CORE_W | Readback: chosen core |
| rb_relock | output | 1 | Readback: pending relock request |

## Verification
The bench builds the block with `WIN_CYCLES` = 4 and the default increment width, which gives a count width of 11 bits. With this setting a full run of ten windows takes only about 60 cycles, so many random runs fit in the time budget.

The bench's own oscillator model gives counts from 92 to 1000 across the three overlapping cores. Targets above every count drive the search down to band 0. A target of 0 drives it up to band 127. Both failure codes, exact survey ties and both banks can therefore be reached with small 11-bit targets.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CORE   = 2'd1,
        ST_BAND   = 2'd2,
        ST_FINISH = 2'd3
    } cal_state_t;
endpackage

// File: rtl/vbc_trigger.sv
module vbc_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic relock_wr,
    input  logic accept,
    output logic start_req,
    output logic relock_bit
);
    logic en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            relock_bit <= 1'b0;
        end else begin
            en_q <= enable;
            // A new write wins over a simultaneous acceptance, so the request is not lost.
            if (relock_wr)
                relock_bit <= 1'b1;
            else if (accept)
                relock_bit <= 1'b0;
        end
    end

    assign start_req = (enable & ~en_q) | relock_bit;
endmodule

// File: rtl/vbc_window_meas.sv
module vbc_window_meas #(
    parameter int WIN_CYCLES = 32,
    parameter int INC_W      = 8,
    parameter int CNT_W      = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [INC_W-1:0] osc_inc,
    output logic [CNT_W-1:0] count,
    output logic             valid
);
    localparam int LEFT_W = $clog2(WIN_CYCLES + 1);

    logic [LEFT_W-1:0] left_q;
    logic              act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            left_q <= '0;
            act_q  <= 1'b0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (start) begin
                count  <= '0;
                left_q <= LEFT_W'(WIN_CYCLES);
                act_q  <= 1'b1;
            end else if (act_q) begin
                count  <= count + CNT_W'(osc_inc);
                left_q <= left_q - 1'b1;
                if (left_q == LEFT_W'(1)) begin
                    act_q <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vbc_core_pick.sv
module vbc_core_pick #(
    parameter int CORE_W = 2,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CORE_W-1:0] idx,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  target,
    output logic [CORE_W-1:0] best_next
);
    logic [CORE_W-1:0] best_q;
    logic [CNT_W-1:0]  best_diff_q;
    logic [CNT_W-1:0]  diff;
    logic              better;

    always_comb begin
        diff      = (count >= target) ? (count - target) : (target - count);
        // Core 0 always seeds the survey; later cores need a strictly smaller error.
        better    = (idx == '0) || (diff < best_diff_q);
        best_next = (load && better) ? idx : best_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_q      <= '0;
            best_diff_q <= '0;
        end else if (load && better) begin
            best_q      <= idx;
            best_diff_q <= diff;
        end
    end
endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal #(
    parameter  int NUM_CORES  = 3,
    parameter  int BAND_W     = 7,
    parameter  int WIN_CYCLES = 32,
    parameter  int INC_W      = 8,
    localparam int CNT_W      = INC_W + $clog2(WIN_CYCLES + 1),
    localparam int CORE_W     = $clog2(NUM_CORES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              relock_wr,
    input  logic              mode,
    input  logic [CNT_W-1:0]  bank0_target,
    input  logic [CNT_W-1:0]  bank1_target,
    input  logic [INC_W-1:0]  osc_inc,
    output logic [CORE_W-1:0] core_sel,
    output logic [BAND_W-1:0] band_sel,
    output logic              busy,
    output logic              done,
    output logic              lock_en,
    output logic [BAND_W-1:0] rb_band,
    output logic              rb_fail,
    output logic [CORE_W-1:0] rb_core,
    output logic              rb_relock
);
    import vbc_pkg::*;

    localparam logic [BAND_W-1:0] MID_BAND  = BAND_W'(1) << (BAND_W - 1);
    localparam logic [BAND_W-1:0] MAX_BAND  = '1;
    localparam logic [CORE_W-1:0] LAST_CORE = CORE_W'(NUM_CORES - 1);

    cal_state_t        state_q, state_d;
    logic [BAND_W-1:0] band_q, bit_q;
    logic [CORE_W-1:0] core_q;
    logic [CNT_W-1:0]  target_q;
    logic              meas_start_q;
    logic              lock_q;
    logic              start_req, accept;
    logic [CNT_W-1:0]  meas_count;
    logic              meas_valid;
    logic [CORE_W-1:0] best_next;
    logic              keep;
    logic [BAND_W-1:0] resolved;

    vbc_trigger u_trigger (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .relock_wr  (relock_wr),
        .accept     (accept),
        .start_req  (start_req),
        .relock_bit (rb_relock)
    );

    vbc_window_meas #(
        .WIN_CYCLES (WIN_CYCLES),
        .INC_W      (INC_W),
        .CNT_W      (CNT_W)
    ) u_meas (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (meas_start_q),
        .osc_inc (osc_inc),
        .count   (meas_count),
        .valid   (meas_valid)
    );

    vbc_core_pick #(
        .CORE_W (CORE_W),
        .CNT_W  (CNT_W)
    ) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state_q == ST_CORE && meas_valid),
        .idx       (core_q),
        .count     (meas_count),
        .target    (target_q),
        .best_next (best_next)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_req) state_d = ST_CORE;
            ST_CORE:   if (meas_valid && core_q == LAST_CORE) state_d = ST_BAND;
            ST_BAND:   if (meas_valid && bit_q[0]) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_FINISH);
        accept   = (state_q == ST_IDLE) && start_req;
        lock_en  = lock_q;
        core_sel = core_q;
        band_sel = band_q;
        keep     = (meas_count > target_q);
        resolved = keep ? band_q : (band_q & ~bit_q);
    end

    // Trial sequencing and readback
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            band_q       <= '0;
            bit_q        <= '0;
            core_q       <= '0;
            target_q     <= '0;
            meas_start_q <= 1'b0;
            lock_q       <= 1'b0;
            rb_band      <= '0;
            rb_fail      <= 1'b0;
            rb_core      <= '0;
        end else begin
            meas_start_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        target_q     <= mode ? bank1_target : bank0_target;
                        core_q       <= '0;
                        band_q       <= MID_BAND;
                        meas_start_q <= 1'b1;
                        lock_q       <= 1'b0;
                    end
                end
                ST_CORE: begin
                    if (meas_valid) begin
                        if (core_q != LAST_CORE) begin
                            core_q <= core_q + 1'b1;
                        end else begin
                            core_q <= best_next;
                            bit_q  <= MID_BAND;
                        end
                        band_q       <= MID_BAND;
                        meas_start_q <= 1'b1;
                    end
                end
                ST_BAND: begin
                    if (meas_valid) begin
                        if (bit_q[0]) begin
                            band_q  <= resolved;
                            rb_band <= resolved;
                            rb_core <= core_q;
                            rb_fail <= (resolved == '0) || (resolved == MAX_BAND);
                        end else begin
                            bit_q        <= bit_q >> 1;
                            band_q       <= resolved | (bit_q >> 1);
                            meas_start_q <= 1'b1;
                        end
                    end
                end
                ST_FINISH: lock_q <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vbc_checker.sv
module vbc_checker #(
    parameter int NUM_CORES = 3,
    parameter int CORE_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              relock_wr,
    input logic [CORE_W-1:0] core_sel,
    input logic              busy,
    input logic              done,
    input logic              lock_en,
    input logic              rb_relock
);
    a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_lock_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_en) |-> $past(done));

    a_r9_lock_low_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !lock_en);

    a_r4_core_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        core_sel < CORE_W'(NUM_CORES));

    a_r1_run_has_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(enable) || $past(rb_relock)));

    a_r2_relock_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !$past(relock_wr)) |-> !rb_relock);
endmodule

bind vco_band_cal vbc_checker #(
    .NUM_CORES (NUM_CORES),
    .CORE_W    (CORE_W)
) i_vbc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .relock_wr (relock_wr),
    .core_sel  (core_sel),
    .busy      (busy),
    .done      (done),
    .lock_en   (lock_en),
    .rb_relock (rb_relock)
);

// File: tb/test_vco_band_cal.sv
`timescale 1ns/1ps
module test_vco_band_cal;
    localparam int WIN   = 4;
    localparam int INC_W = 8;
    localparam int CNT_W = INC_W + $clog2(WIN + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             relock_wr = 1'b0;
    logic             mode = 1'b0;
    logic [CNT_W-1:0] bank0_target = '0;
    logic [CNT_W-1:0] bank1_target = '0;
    logic [INC_W-1:0] osc_inc;
    logic [1:0]       core_sel;
    logic [6:0]       band_sel;
    logic             busy, done, lock_en, rb_fail, rb_relock;
    logic [6:0]       rb_band;
    logic [1:0]       rb_core;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int busy_rises = 0;
    logic busy_prev = 1'b0;

    always #2.5 clk = ~clk;

    vco_band_cal #(.NUM_CORES(3), .BAND_W(7), .WIN_CYCLES(WIN), .INC_W(INC_W)) i_vco_band_cal (
        .clk(clk), .rst_n(rst_n), .enable(enable), .relock_wr(relock_wr), .mode(mode),
        .bank0_target(bank0_target), .bank1_target(bank1_target), .osc_inc(osc_inc),
        .core_sel(core_sel), .band_sel(band_sel), .busy(busy), .done(done),
        .lock_en(lock_en), .rb_band(rb_band), .rb_fail(rb_fail), .rb_core(rb_core),
        .rb_relock(rb_relock)
    );

    // Oscillator model: per-cycle edge increment falls by one per band step.
    function automatic int base_rate(int c);
        return (c == 0) ? 250 : (c == 1) ? 200 : 150;
    endfunction

    assign osc_inc = INC_W'(base_rate(int'(core_sel)) - int'(band_sel));

    function automatic int model_count(int c, int b);
        return WIN * (base_rate(c) - b);
    endfunction

    function automatic int ref_core(int t);
        int best = 0;
        int bd = 1 << 30;
        for (int c = 0; c < 3; c++) begin
            int d = model_count(c, 64) - t;
            if (d < 0) d = -d;
            if (d < bd) begin bd = d; best = c; end
        end
        return best;
    endfunction

    function automatic int ref_band(int c, int t);
        int b = 0;
        for (int i = 6; i >= 0; i--) begin
            int tr = b | (1 << i);
            if (model_count(c, tr) > t) b = tr;
        end
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    always @(posedge clk) begin
        if (rst_n && busy && !busy_prev) busy_rises++;
        busy_prev <= busy;
    end

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
        check(seen, "R8 done timeout", 0, 1);
    endtask

    // Checks the outcome in the done cycle and the cycle after it.
    task automatic check_result(input int t);
        int ec = ref_core(t);
        int eb = ref_band(ec, t);
        int ef = (eb == 0 || eb == 127) ? 1 : 0;
        check(int'(rb_core) == ec, "R4 core", int'(rb_core), ec);
        check(int'(rb_band) == eb, "R5 band", int'(rb_band), eb);
        check(int'(rb_fail) == ef, "R7 fail flag", int'(rb_fail), ef);
        check(busy == 1'b1, "R8 busy at done", int'(busy), 1);
        @(negedge clk);
        check(lock_en == 1'b1, "R9 lock after done", int'(lock_en), 1);
        check(done == 1'b0, "R8 done pulse", int'(done), 0);
    endtask

    task automatic do_run(input bit by_relock, input bit md, input int t0, input int t1);
        bit seen;
        bank0_target = CNT_W'(t0);
        bank1_target = CNT_W'(t1);
        mode = md;
        if (by_relock) begin
            relock_wr = 1'b1;
            @(negedge clk);
            relock_wr = 1'b0;
            check(rb_relock == 1'b1, "R2 relock visible", int'(rb_relock), 1);
        end else begin
            enable = 1'b1;
        end
        repeat (4) @(negedge clk);
        check(busy == 1'b1, "R8 busy in run", int'(busy), 1);
        check(lock_en == 1'b0, "R9 lock low in run", int'(lock_en), 0);
        if (by_relock) check(rb_relock == 1'b0, "R2 relock cleared", int'(rb_relock), 0);
        wait_done(seen);
        if (seen) check_result(md ? t1 : t0);
        enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int r0;
        bit seen;
        void'($urandom(32'd5123));
        repeat (3) @(negedge clk);
        // R10: reset values
        check(busy == 0 && done == 0 && lock_en == 0, "R10 control reset", int'({busy, done, lock_en}), 0);
        check(rb_band == 0 && rb_fail == 0, "R10 band reset", int'(rb_band), 0);
        check(rb_core == 0 && rb_relock == 0, "R10 core reset", int'(rb_core), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 / R7: target above every count -> band 0, failure
        do_run(1'b0, 1'b0, 2000, 0);
        // R2 / R7: target 0 -> core 2, band 127, failure
        do_run(1'b1, 1'b0, 0, 0);
        // R4: exact tie between cores 0 and 1 -> core 0
        do_run(1'b0, 1'b0, 644, 0);
        // R6: mode picks bank 1, then bank 0
        do_run(1'b0, 1'b1, 400, 800);
        do_run(1'b1, 1'b0, 400, 800);

        // R1: holding enable high starts no second run
        r0 = busy_rises;
        enable = 1'b1;
        bank0_target = CNT_W'(500);
        mode = 1'b0;
        wait_done(seen);
        repeat (40) @(negedge clk);
        check(busy_rises == r0 + 1, "R1 level no retrigger", busy_rises - r0, 1);

        // R3: enable re-raised during a run is ignored
        enable = 1'b0;
        @(negedge clk);
        r0 = busy_rises;
        enable = 1'b1;
        repeat (10) @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        wait_done(seen);
        if (seen) check_result(500);
        repeat (40) @(negedge clk);
        check(busy_rises == r0 + 1, "R3 rise during run ignored", busy_rises - r0, 1);
        enable = 1'b0;
        @(negedge clk);

        // R2: relock written mid-run is held and starts a second run
        r0 = busy_rises;
        bank0_target = CNT_W'(300);
        enable = 1'b1;
        repeat (10) @(negedge clk);
        relock_wr = 1'b1;
        @(negedge clk);
        relock_wr = 1'b0;
        check(rb_relock == 1'b1, "R2 relock held in run", int'(rb_relock), 1);
        wait_done(seen);
        if (seen) check_result(300);
        wait_done(seen);
        if (seen) check_result(300);
        check(busy_rises == r0 + 2, "R2 queued run", busy_rises - r0, 2);
        check(rb_relock == 1'b0, "R2 relock cleared after queue", int'(rb_relock), 0);
        enable = 1'b0;
        @(negedge clk);

        // Random runs across both banks and both trigger kinds
        for (int n = 0; n < 30; n++) begin
            do_run(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   int'($urandom_range(0, 1100)), int'($urandom_range(0, 1100)));
        end

        finish_run();
    end
endmodule